// File: doc/BRIEF.md
# DMA Item Width and Lane Alignment Path

This block handles the data side of one DMA item. The item is the step between the read phase and the write phase. It accepts a size code and a working address for the source and for the destination. It drives one read phase and then one write phase. Each phase presents an address aligned to the item size, together with the size code for that phase. The 32-bit word returned by the read is held in a register between the two phases. The block picks the source item out of that word, fits it to the destination width and places it on the write bus.

A channel sequencer sits above the block. It pulses `start` with the item parameters. It answers the read request with `rd_valid` and the read word, and it takes the single-cycle write request. Address incrementing, channel sequencing and arbitration are handled elsewhere. Any reserved size code is refused: the block raises a one-cycle configuration error and issues no access on either phase.

Top module: `dma_lane_path`

## Requirements
- R1: Size codes are 00 for 8 bits, 01 for 16 bits and 10 for 32 bits. `rd_size` equals the source code and `wr_size` equals the destination code while the matching request is high.
- R2: For a 16-bit side, address bit 0 is forced to zero. For a 32-bit side, address bits 1:0 are forced to zero. Byte addresses pass through unchanged. This applies to both `rd_addr` and `wr_addr`.
- R3: The source item is taken from the read word in little-endian order. A byte item comes from bits [8*a+7:8*a], and a half-word item comes from bits [16*a1+15:16*a1], where a is the aligned source address modulo 4 and a1 is bit 1 of that address.
- R4: When the destination is wider than the source, the item is zero-extended. For example, byte B0 is written as 0x00B0 or as 0x000000B0.
- R5: When the destination is narrower than the source, only the low destination-width part of the item is written. For example, a word B3B2B1B0 written as 16 bits gives B1B0.
- R6: A byte write repeats its byte on all four lanes, and a half-word write repeats its half-word on both halves of `wr_data`.
- R7: A `start` with code 11 on either side raises `cfg_err` for exactly the next cycle. Neither `rd_req` nor `wr_req` is asserted for that item.
- R8: For a valid `start`, `rd_req` rises on the next cycle and holds with a stable address until `rd_valid` is seen. The read word is captured on that cycle. `wr_req` is then high for exactly one cycle, and later changes on `rd_data` do not affect it.
- R9: A `start` that arrives while an item is in progress is ignored.
- R10: After reset, `rd_req`, `wr_req` and `cfg_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one item; sampled only when idle |
| src_size | input | 2 | Source size code |
| dst_size | input | 2 | Destination size code |
| src_addr | input | AW | Source working address |
| dst_addr | input | AW | Destination working address |
| rd_valid | input | 1 | Read word is present on rd_data |
| rd_data | input | DW | Read word |
| cfg_err | output | 1 | One-cycle pulse for a reserved size code |
| rd_req | output | 1 | Read phase request |
| rd_addr | output | AW | Aligned source address |
| rd_size | output | 2 | Read transfer size code |
| wr_req | output | 1 | Write phase request, one cycle |
| wr_addr | output | AW | Aligned destination address |
| wr_size | output | 2 | Write transfer size code |
| wr_data | output | DW | Write word with lanes placed and replicated |

## Verification
Two functions can act in the same cycle: the read word is captured while a new `start` is offered, or while `rd_data` is already changing to a different value. The bench offers a `start` with reserved codes in the middle of every read phase. It then checks that `cfg_err` stays low and that `rd_addr` has not moved. On the cycle after capture it drives a different value onto `rd_data` and checks that `wr_data` still matches the value computed from the word present when `rd_valid` was high. The sweep covers every pair of sizes, every pair of address offsets and two data words, and also every reserved combination.

// File: rtl/dma_lane_pkg.sv
package dma_lane_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_READ  = 2'b01,
        PH_WRITE = 2'b10
    } phase_e;

endpackage

// File: rtl/dma_lane_align.sv
module dma_lane_align
    import dma_lane_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  size_e         size,
    output logic [AW-1:0] aligned
);
    always_comb begin
        aligned = addr;
        unique case (size)
            SZ_HALF: aligned[0]   = 1'b0;
            SZ_WORD: aligned[1:0] = 2'b00;
            default: aligned      = addr;
        endcase
    end
endmodule

// File: rtl/dma_lane_pack.sv
module dma_lane_pack
    import dma_lane_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] raw,
    input  size_e         src_size,
    input  logic [1:0]    src_lsb,
    input  size_e         dst_size,
    output logic [DW-1:0] packed_out
);
    localparam int NLANE = DW / 8;

    logic [DW-1:0] shifted;
    logic [DW-1:0] src_mask;
    logic [DW-1:0] dst_mask;
    logic [DW-1:0] item;

    function automatic logic [DW-1:0] width_mask(size_e s);
        logic [DW-1:0] m;
        m = '0;
        unique case (s)
            SZ_BYTE: m[7:0]  = 8'hFF;
            SZ_HALF: m[15:0] = 16'hFFFF;
            default: m[31:0] = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

    always_comb begin
        shifted  = raw >> {src_lsb, 3'b000};
        src_mask = width_mask(src_size);
        dst_mask = width_mask(dst_size);
        item     = shifted & src_mask & dst_mask;
    end

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        always_comb begin
            unique case (dst_size)
                SZ_BYTE: packed_out[l*8 +: 8] = item[7:0];
                SZ_HALF: packed_out[l*8 +: 8] = item[(l % 2)*8 +: 8];
                default: packed_out[l*8 +: 8] = item[(l % 4)*8 +: 8];
            endcase
        end
    end
endmodule

// File: rtl/dma_lane_path.sv
module dma_lane_path
    import dma_lane_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    src_size,
    input  logic [1:0]    dst_size,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_data,
    output logic          cfg_err,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic [1:0]    rd_size,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [1:0]    wr_size,
    output logic [DW-1:0] wr_data
);
    typedef struct packed {
        phase_e        phase;
        logic          err;
        size_e         ssz;
        size_e         dsz;
        logic [AW-1:0] sadr;
        logic [AW-1:0] dadr;
        logic [DW-1:0] word;
    } item_state_t;

    item_state_t st_d, st_q;
    logic [AW-1:0] src_aln, dst_aln;

    dma_lane_align #(.AW(AW)) u_src_align (
        .addr(src_addr), .size(size_e'(src_size)), .aligned(src_aln)
    );
    dma_lane_align #(.AW(AW)) u_dst_align (
        .addr(dst_addr), .size(size_e'(dst_size)), .aligned(dst_aln)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    if (src_size == SZ_RSVD || dst_size == SZ_RSVD) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.phase = PH_READ;
                        st_d.ssz   = size_e'(src_size);
                        st_d.dsz   = size_e'(dst_size);
                        st_d.sadr  = src_aln;
                        st_d.dadr  = dst_aln;
                    end
                end
            end
            PH_READ: begin
                if (rd_valid) begin
                    st_d.word  = rd_data;
                    st_d.phase = PH_WRITE;
                end
            end
            PH_WRITE: st_d.phase = PH_IDLE;
            default:  st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dma_lane_pack #(.DW(DW)) u_pack (
        .raw(st_q.word), .src_size(st_q.ssz), .src_lsb(st_q.sadr[1:0]),
        .dst_size(st_q.dsz), .packed_out(wr_data)
    );

    assign cfg_err = st_q.err;
    assign rd_req  = (st_q.phase == PH_READ);
    assign rd_addr = st_q.sadr;
    assign rd_size = st_q.ssz;
    assign wr_req  = (st_q.phase == PH_WRITE);
    assign wr_addr = st_q.dadr;
    assign wr_size = st_q.dsz;
endmodule

// File: rtl/dma_lane_path_chk.sv
module dma_lane_path_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_err,
    input logic          rd_req,
    input logic          rd_valid,
    input logic [AW-1:0] rd_addr,
    input logic [1:0]    rd_size,
    input logic          wr_req,
    input logic [AW-1:0] wr_addr,
    input logic [1:0]    wr_size,
    input logic [DW-1:0] wr_data
);
    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!rd_req && !wr_req));
    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
    // R8
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req);
    // R8
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |-> $past(rd_req && rd_valid));
    // R1
    size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req |-> rd_size != 2'b11) and (wr_req |-> wr_size != 2'b11));
    // R2
    addr_natural_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_req && rd_size == 2'b10) |-> rd_addr[1:0] == 2'b00) and
        ((wr_req && wr_size == 2'b01) |-> wr_addr[0] == 1'b0));
    // R6
    lane_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_req && wr_size == 2'b00) |-> (wr_data[31:24] == wr_data[7:0])) and
        ((wr_req && wr_size == 2'b01) |-> (wr_data[31:16] == wr_data[15:0])));
endmodule

bind dma_lane_path dma_lane_path_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_err(cfg_err), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_size(rd_size),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data)
);

// File: tb/dma_lane_path_test.sv
module dma_lane_path_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  src_size = 2'b00, dst_size = 2'b00;
    logic [31:0] src_addr = '0, dst_addr = '0;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        cfg_err, rd_req, wr_req;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic [1:0]  rd_size, wr_size;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_lane_path #(.AW(32), .DW(32)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_size(src_size),
        .dst_size(dst_size), .src_addr(src_addr), .dst_addr(dst_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .cfg_err(cfg_err),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] align_exp(input logic [31:0] a, input int sz);
        int nb = 1 << sz;
        return a - (a % nb);
    endfunction

    function automatic logic [31:0] wdata_exp(input logic [31:0] raw, input int ss,
                                              input int ds, input logic [31:0] sa);
        int sb = 1 << ss;
        int db = 1 << ds;
        int mb = (sb < db) ? sb : db;
        int off = int'(sa % 4);
        longint item;
        longint res = 0;
        item = longint'(raw) >> (8 * off);
        item = item & ((64'd1 << (8 * mb)) - 1);
        for (int k = 0; k < 4 / db; k++) res = res | (item << (8 * db * k));
        return res[31:0];
    endfunction

    task automatic run_item(input int ss, input int ds, input logic [31:0] sa,
                            input logic [31:0] da, input logic [31:0] raw);
        logic [31:0] esa, eda;
        @(negedge clk);
        src_size = ss[1:0]; dst_size = ds[1:0]; src_addr = sa; dst_addr = da;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (ss == 3 || ds == 3) begin
            chk(cfg_err == 1'b1, "R7 err pulse", 32'(cfg_err), 32'd1);
            chk(!rd_req && !wr_req, "R7 no access", {30'd0, rd_req, wr_req}, 32'd0);
            @(negedge clk);
            chk(cfg_err == 1'b0, "R7 err one cycle", 32'(cfg_err), 32'd0);
            chk(!rd_req && !wr_req, "R7 still idle", {30'd0, rd_req, wr_req}, 32'd0);
            return;
        end
        esa = align_exp(sa, ss);
        eda = align_exp(da, ds);
        chk(rd_req == 1'b1, "R8 read issued", 32'(rd_req), 32'd1);
        chk(rd_addr == esa, "R2 read addr", rd_addr, esa);
        chk(rd_size == ss[1:0], "R1 read size", 32'(rd_size), 32'(ss));
        // R9: a reserved start offered mid-read must be ignored
        src_size = 2'b11; src_addr = ~sa; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cfg_err == 1'b0, "R9 busy start ignored", 32'(cfg_err), 32'd0);
        chk(rd_req && rd_addr == esa, "R9 read addr held", rd_addr, esa);
        rd_valid = 1'b1; rd_data = raw;
        @(negedge clk);
        rd_valid = 1'b0; rd_data = ~raw;
        chk(wr_req == 1'b1, "R8 write issued", 32'(wr_req), 32'd1);
        chk(!rd_req, "R8 read dropped", 32'(rd_req), 32'd0);
        chk(wr_addr == eda, "R2 write addr", wr_addr, eda);
        chk(wr_size == ds[1:0], "R1 write size", 32'(wr_size), 32'(ds));
        chk(wr_data == wdata_exp(raw, ss, ds, esa),
            (ss < ds) ? "R4 zero extend" : (ss > ds) ? "R5 truncate" :
            (ds < 2) ? "R6 replicate" : "R3 lane pick",
            wr_data, wdata_exp(raw, ss, ds, esa));
        @(negedge clk);
        chk(!wr_req, "R8 write one cycle", 32'(wr_req), 32'd0);
    endtask

    initial begin
        logic [31:0] pats [2];
        pats[0] = 32'hB3B2_B1B0;
        pats[1] = 32'h8C5A_17E4;
        repeat (3) @(negedge clk);
        chk(!rd_req && !wr_req && !cfg_err, "R10 reset idle",
            {29'd0, rd_req, wr_req, cfg_err}, 32'd0);
        rst_n = 1'b1;
        for (int ss = 0; ss < 4; ss++)
            for (int ds = 0; ds < 4; ds++)
                for (int so = 0; so < 4; so++)
                    for (int dof = 0; dof < 4; dof++)
                        for (int p = 0; p < 2; p++)
                            run_item(ss, ds, 32'h2000_0100 + 32'(so) + 32'(p * 16),
                                     32'h4001_3800 + 32'(dof) + 32'(ss * 64),
                                     pats[p]);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule